// File: doc/BRIEF.md
# Synchronous BCD Decade Counter with Gated Clear and Preset

This block is a fully synchronous four-bit decade counter. While its count enable is high it steps through the decimal digits in binary weighting: the most significant output bit carries weight 8 and the least significant carries weight 1. After the last digit it wraps to zero. Two AND-gated control pairs override counting. The clear pair forces the count to zero and the preset pair forces it to nine. A gate acts only when both of its inputs are high, and the clear pair wins over the preset pair.

A terminal-count output marks the last digit of the cycle while counting is enabled, so several counters can be chained. A shorter cycle can be built in two ways. The first is a parameter that sets an internal modulus. The second is wiring count bits back into the clear pair. Because that clear is synchronous, the feedback state is held for exactly one clock before the clear takes effect. A chip-level asynchronous reset puts the count at zero.

Top module: `decade_counter`

## Requirements
- R1: With `countEn` high and neither gate active, the count `qOut` rises by one on each rising clock edge. With the default modulus of 10 it runs 0 to 9 and goes from 9 to 0. `qOut[3]` has weight 8 and `qOut[0]` has weight 1.
- R2: With `countEn` low and neither gate active, `qOut` holds its value on every clock edge.
- R3: When `clrA` and `clrB` are both high at a rising edge, `qOut` becomes 0 at that edge, whatever the enable or the preset pair do. Either input high on its own has no effect on counting.
- R4: When `setA` and `setB` are both high at a rising edge and the clear gate is not active, `qOut` becomes 9 (binary 1001) at that edge. Either input high on its own has no effect on counting.
- R5: When both gates are active at the same edge, the clear gate wins and `qOut` becomes 0.
- R6: `termCnt` is high exactly while `countEn` is high and `qOut` equals MOD_N-1, which is 9 by default. It goes low as soon as either condition stops holding.
- R7: With MOD_N below 10, the count runs 0 to MOD_N-1 and then returns to 0. A value of MOD_N or above can be reached through the preset. Such a value returns to 0 on the next edge when neither gate is active, even with `countEn` low.
- R8: With `clrA` wired to `qOut[0]` and `clrB` wired to `qOut[2]`, counting from 0 gives 1, 2, 3, 4, then 5 for one cycle, then 0. The value 5 is never held for more than one clock.
- R9: While `rstN` is low, `qOut` is 0 and `termCnt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low chip reset |
| countEn | input | 1 | Count enable |
| clrA | input | 1 | Clear gate input A |
| clrB | input | 1 | Clear gate input B |
| setA | input | 1 | Preset-to-nine gate input A |
| setB | input | 1 | Preset-to-nine gate input B |
| qOut | output | CNT_W (4) | Count value, bit 3 most significant |
| termCnt | output | 1 | Terminal count, combinational |

## Verification
Every count, clear, preset and wrap result appears on `qOut` at the first rising edge after the inputs are set. `termCnt` follows the count and the enable in the same cycle, with no added register. The bench therefore changes inputs 1 ns after a rising edge and samples the outputs at that same point. The result it reads there comes from exactly one preceding edge. In the feedback test the sequence is sampled edge by edge, so the one-cycle appearance of 5 is checked at the exact cycle it occurs.

// File: rtl/decade_pkg.sv
package decade_pkg;
  // Strobes from control to datapath; at most one is high in a cycle.
  typedef struct packed {
    logic clear;
    logic preset;
    logic step;
  } cnt_strobe_t;
endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int MOD_N      = 10,
  parameter int PRESET_VAL = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             clrA,
  input  logic             clrB,
  input  logic             setA,
  input  logic             setB,
  input  logic [CNT_W-1:0] countQ,
  output cnt_strobe_t      strobes,
  output logic             termCnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD_N - 1);
  localparam logic [CNT_W-1:0] PVAL = CNT_W'(PRESET_VAL);

  logic gatedClr, gatedSet, atLast, outOfRange;

  assign gatedClr = clrA & clrB;
  assign gatedSet = setA & setB;
  assign atLast   = (countQ == LAST);

  // A range check is only needed when the modulus leaves unused codes.
  generate
    if (MOD_N < (1 << CNT_W)) begin : g_range
      assign outOfRange = (countQ > LAST);
    end else begin : g_full
      assign outOfRange = 1'b0;
    end
  endgenerate

  // Priority: gated clear, gated preset, range recovery / wrap, step.
  always_comb begin
    strobes.clear  = gatedClr | (~gatedSet & (outOfRange | (countEn & atLast)));
    strobes.preset = gatedSet & ~gatedClr;
    strobes.step   = countEn & ~gatedClr & ~gatedSet & ~outOfRange & ~atLast;
  end

  assign termCnt = countEn & atLast;

  // R3
  clr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrA && clrB) |=> (countQ == '0));

  // R4
  preset_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setA && setB && !(clrA && clrB)) |=> (countQ == PVAL));

  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !(clrA && clrB) && !(setA && setB) && countQ < LAST)
      |=> (countQ == $past(countQ) + 1'b1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !(clrA && clrB) && !(setA && setB) && countQ <= LAST)
      |=> $stable(countQ));

  // R6
  tc_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (termCnt && !(setA && setB)) |=> (countQ == '0));

  // R7
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countQ > LAST && !(setA && setB)) |=> (countQ == '0));
endmodule

// File: rtl/decade_dp.sv
module decade_dp
  import decade_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int PRESET_VAL = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strobes,
  output logic [CNT_W-1:0] countQ
);
  localparam logic [CNT_W-1:0] PVAL = CNT_W'(PRESET_VAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               countQ <= '0;
    else if (strobes.clear)  countQ <= '0;
    else if (strobes.preset) countQ <= PVAL;
    else if (strobes.step)   countQ <= countQ + 1'b1;
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clear, strobes.preset, strobes.step}));
endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import decade_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int MOD_N      = 10,
  parameter int PRESET_VAL = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             clrA,
  input  logic             clrB,
  input  logic             setA,
  input  logic             setB,
  output logic [CNT_W-1:0] qOut,
  output logic             termCnt
);
  cnt_strobe_t strobes;

  decade_ctrl #(.CNT_W(CNT_W), .MOD_N(MOD_N), .PRESET_VAL(PRESET_VAL)) ctrl_i (
    .clk(clk), .rstN(rstN), .countEn(countEn),
    .clrA(clrA), .clrB(clrB), .setA(setA), .setB(setB),
    .countQ(qOut), .strobes(strobes), .termCnt(termCnt)
  );

  decade_dp #(.CNT_W(CNT_W), .PRESET_VAL(PRESET_VAL)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .countQ(qOut)
  );

  // R9
  reset_out_chk: assert property (@(posedge clk) !rstN |-> (qOut == '0 && !termCnt));
endmodule

// File: tb/decade_counter_tb.sv
`timescale 1ns/1ps
module decade_counter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic countEn = 1'b0;
  logic clrADrv = 1'b0, clrBDrv = 1'b0, setA = 1'b0, setB = 1'b0;
  logic fbMode = 1'b0;
  logic clrA, clrB;
  logic [3:0] qOut, q5;
  logic termCnt, tc5;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign clrA = fbMode ? qOut[0] : clrADrv;
  assign clrB = fbMode ? qOut[2] : clrBDrv;

  decade_counter dut_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .clrA(clrA), .clrB(clrB),
    .setA(setA), .setB(setB), .qOut(qOut), .termCnt(termCnt)
  );

  decade_counter #(.MOD_N(5)) dut_mod5_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .clrA(clrADrv), .clrB(clrBDrv),
    .setA(setA), .setB(setB), .qOut(q5), .termCnt(tc5)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Advance n edges; inputs and samples sit 1 ns after the edge.
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clearBoth();
    clrADrv = 1'b1; clrBDrv = 1'b1;
    tick(1);
    clrADrv = 1'b0; clrBDrv = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; countEn = 1'b1;
    tick(2);
    chk("R9 count in reset", qOut, 0);
    chk("R9 tc in reset", termCnt, 0);
    countEn = 1'b0;
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic t_count();
    countEn = 1'b1;
    for (int i = 0; i < 21; i++) begin
      chk("R1 decade sequence", qOut, i % 10);
      chk("R6 tc while counting", termCnt, (i % 10) == 9);
      tick(1);
    end
  endtask

  task automatic t_hold();
    // qOut is now 1; move to 9 then freeze.
    tick(8);
    chk("R1 reached nine", qOut, 9);
    countEn = 1'b0;
    #0.5;
    chk("R6 tc low when disabled", termCnt, 0);
    tick(3);
    chk("R2 hold at nine", qOut, 9);
    countEn = 1'b1;
    tick(1);
    chk("R1 wrap nine to zero", qOut, 0);
  endtask

  task automatic t_clear();
    tick(3);
    clrADrv = 1'b1;
    tick(1);
    chk("R3 single clear input ignored", qOut, 4);
    clrADrv = 1'b0; clrBDrv = 1'b1;
    tick(1);
    chk("R3 other clear input ignored", qOut, 5);
    clrADrv = 1'b1;
    tick(1);
    chk("R3 gated clear while enabled", qOut, 0);
    clrADrv = 1'b0; clrBDrv = 1'b0;
  endtask

  task automatic t_preset();
    tick(2);
    setA = 1'b1;
    tick(1);
    chk("R4 single preset input ignored", qOut, 3);
    setA = 1'b0; setB = 1'b1;
    tick(1);
    chk("R4 other preset input ignored", qOut, 4);
    setA = 1'b1; countEn = 1'b0;
    tick(1);
    chk("R4 gated preset to nine", qOut, 9);
    clrADrv = 1'b1; clrBDrv = 1'b1;
    tick(1);
    chk("R5 clear wins over preset", qOut, 0);
    clrADrv = 1'b0; clrBDrv = 1'b0; setA = 1'b0; setB = 1'b0;
  endtask

  task automatic t_mod5();
    clearBoth();
    countEn = 1'b1;
    for (int i = 0; i < 11; i++) begin
      chk("R7 mod5 sequence", q5, i % 5);
      chk("R7 mod5 tc", tc5, (i % 5) == 4);
      tick(1);
    end
    countEn = 1'b0;
    setA = 1'b1; setB = 1'b1;
    tick(1);
    setA = 1'b0; setB = 1'b0;
    chk("R7 preset beyond modulus", q5, 9);
    tick(1);
    chk("R7 out-of-range recovers while disabled", q5, 0);
  endtask

  task automatic t_feedback();
    clearBoth();
    fbMode = 1'b1;
    countEn = 1'b1;
    chk("R8 feedback start", qOut, 0);
    for (int i = 1; i < 9; i++) begin
      tick(1);
      chk("R8 feedback sequence", qOut, i % 6);
    end
    fbMode = 1'b0;
    countEn = 1'b0;
  endtask

  initial begin
    tick(1);
    t_reset();
    t_count();
    t_hold();
    t_clear();
    t_preset();
    t_mod5();
    t_feedback();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule